// File: doc/BRIEF.md
# Power-Change System-Management Interrupt Controller

This block raises a system-management interrupt (SMI) when software changes the supply of a card socket. Each socket reports two kinds of register write: writes to its socket-control register and writes to its legacy power register. It also reports a strobe that is high when the power-switch interface actually launches a change sequence. An event counts only when one of those writes coincides with a launched sequence. A qualifying event sets that socket's pending flag, and only while generation is enabled.

A shared control word holds three bits: an enable, a shared route selector and a per-socket pending flag. The control word is written with a socket index, and the same index selects which socket's flag is read back. With the route bit at 0, each socket's pending flag drives that socket's own status-change interrupt. That interrupt is a level or a one-cycle pulse, as a global mode input selects. With the route bit at 1, the pending flags go out as IRQ2 instead. In serial-IRQ mode, IRQ2 is a request level toward an external frame generator. In parallel mode, IRQ2 is an active-low pin, and it is driven only when the multifunction mapping selects pin 3 or pin 6.

Top module: `pwr_smi_ctrl`

## Requirements
- R1: After reset, all pending flags, the enable bit and the route bit are 0. All status-change outputs are 0, the serial request is 0, the parallel enable is 0 and the parallel pin is 1.
- R2: A socket's pending flag becomes 1 on the clock edge where that socket has a control-register write or a legacy-power write, its sequence-launch strobe is high, and the enable bit is 1. A write without the launch strobe, or a launch without a write, leaves the flag unchanged.
- R3: Read data carries the route bit at bit 26, the selected socket's pending flag at bit 25 and the enable bit at bit 24. All other read bits are 0. A control write loads route and enable from bits 26 and 24.
- R4: A control write with bit 25 set clears the pending flag of the addressed socket only. A control write with bit 25 clear leaves every flag unchanged.
- R5: If a qualifying event and a clearing write hit the same socket on the same edge, the flag stays 1.
- R6: A qualifying event while the enable bit is 0 never sets the flag, even after the enable bit is set later.
- R7: With route 0 and level mode (`csc_edge_mode`=0), each socket's status-change output equals its pending flag.
- R8: With route 0 and edge mode (`csc_edge_mode`=1), a socket's status-change output is high for exactly the one cycle after its flag rises, and then 0.
- R9: With route 1, every status-change output is 0. In serial mode (`irq_serial_mode`=1), the serial request is the OR of all pending flags, and the parallel enable is 0.
- R10: With route 1 and parallel mode, the parallel enable is 1 only when `mfunc_sel` is 3 or 6. While it is enabled, the pin is low exactly when any flag is pending; otherwise the pin is 1. The serial request is 0 in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_sock | input | 1 | Socket index for write clear and read back |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data for `cfg_sock` |
| sock_ctl_wr | input | 2 | Per-socket socket-control register write |
| legacy_pwr_wr | input | 2 | Per-socket legacy power register write |
| seq_launch | input | 2 | Per-socket power-switch sequence launched |
| csc_edge_mode | input | 1 | Status-change form: 1 pulse, 0 level |
| irq_serial_mode | input | 1 | IRQ2 via serial frame (1) or parallel pin (0) |
| mfunc_sel | input | 3 | Multifunction pin that IRQ2 is mapped to |
| smi_csc | output | 2 | Per-socket status-change interrupt |
| irq2_ser_req | output | 1 | IRQ2 request level for the serial frame generator |
| irq2_par_oe | output | 1 | Parallel IRQ2 pin drive enable |
| irq2_par_n | output | 1 | Parallel IRQ2 pin, active low |

## Verification
The assertions assume that `csc_edge_mode` is held steady around a flag's rise, because a pulse is only well defined for one mode at a time. They also assume that `mfunc_sel` and `irq_serial_mode` are static configuration. The bench changes these mode inputs only while no flag is rising, and it holds each one for several cycles before sampling. Control writes in the bench always carry the enable and route values that are intended to stay in force. This is because every write reloads both shared bits.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int ROUTE_BIT = 26;
  localparam int STAT_BIT  = 25;
  localparam int EN_BIT    = 24;

  // an event counts only when a power write coincides with a launched sequence
  function automatic logic qual_event(input logic ctl_wr, input logic leg_wr,
                                      input logic launch);
    return (ctl_wr | leg_wr) & launch;
  endfunction

  // set has priority over write-one-to-clear
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic irq2_pin_mapped(input logic [2:0] sel);
    return (sel == 3'd3) || (sel == 3'd6);
  endfunction
endpackage

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          en_q,
  output logic          route_q
);
  import smi_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      route_q <= 1'b0;
    end else if (wr) begin
      en_q    <= wdata[EN_BIT];
      route_q <= wdata[ROUTE_BIT];
    end
  end
endmodule

// File: rtl/smi_pend_cell.sv
module smi_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic en,
  input  logic clr,
  output logic pend,
  output logic pend_d
);
  import smi_pkg::*;

  logic set_w;
  assign set_w = trig & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      pend_d <= 1'b0;
    end else begin
      pend   <= flag_next(pend, set_w, clr);
      pend_d <= pend;
    end
  end
endmodule

// File: rtl/smi_out_fmt.sv
module smi_out_fmt #(
  parameter int NSOCK = 2
) (
  input  logic [NSOCK-1:0] pend,
  input  logic [NSOCK-1:0] pend_d,
  input  logic             route,
  input  logic             edge_mode,
  input  logic             ser_mode,
  input  logic [2:0]       mfunc_sel,
  output logic [NSOCK-1:0] smi_csc,
  output logic             ser_req,
  output logic             par_oe,
  output logic             par_n
);
  import smi_pkg::*;

  logic any_pend;
  logic [NSOCK-1:0] rise;

  assign any_pend = |pend;
  assign rise     = pend & ~pend_d;

  always_comb begin
    smi_csc = '0;
    if (!route) smi_csc = edge_mode ? rise : pend;
  end

  assign ser_req = route & ser_mode & any_pend;
  assign par_oe  = route & ~ser_mode & irq2_pin_mapped(mfunc_sel);
  assign par_n   = ~(par_oe & any_pend);
endmodule

// File: rtl/pwr_smi_ctrl.sv
module pwr_smi_ctrl #(
  parameter int NSOCK = 2,
  parameter int DW    = 32,
  localparam int SW   = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [SW-1:0]    cfg_sock,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic [NSOCK-1:0] sock_ctl_wr,
  input  logic [NSOCK-1:0] legacy_pwr_wr,
  input  logic [NSOCK-1:0] seq_launch,
  input  logic             csc_edge_mode,
  input  logic             irq_serial_mode,
  input  logic [2:0]       mfunc_sel,
  output logic [NSOCK-1:0] smi_csc,
  output logic             irq2_ser_req,
  output logic             irq2_par_oe,
  output logic             irq2_par_n
);
  import smi_pkg::*;

  logic             en_q;
  logic             route_q;
  logic [NSOCK-1:0] trig;
  logic [NSOCK-1:0] clr;
  logic [NSOCK-1:0] pend;
  logic [NSOCK-1:0] pend_d;

  smi_cfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .en_q(en_q), .route_q(route_q)
  );

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    assign trig[s] = qual_event(sock_ctl_wr[s], legacy_pwr_wr[s], seq_launch[s]);
    assign clr[s]  = cfg_wr & cfg_wdata[STAT_BIT] & (cfg_sock == SW'(s));
    smi_pend_cell u_cell (
      .clk(clk), .rst_n(rst_n), .trig(trig[s]), .en(en_q), .clr(clr[s]),
      .pend(pend[s]), .pend_d(pend_d[s])
    );
  end

  smi_out_fmt #(.NSOCK(NSOCK)) u_fmt (
    .pend(pend), .pend_d(pend_d), .route(route_q), .edge_mode(csc_edge_mode),
    .ser_mode(irq_serial_mode), .mfunc_sel(mfunc_sel), .smi_csc(smi_csc),
    .ser_req(irq2_ser_req), .par_oe(irq2_par_oe), .par_n(irq2_par_n)
  );

  always_comb begin
    cfg_rdata            = '0;
    cfg_rdata[ROUTE_BIT] = route_q;
    cfg_rdata[EN_BIT]    = en_q;
    cfg_rdata[STAT_BIT]  = (int'(cfg_sock) < NSOCK) ? pend[cfg_sock] : 1'b0;
  end
endmodule

// File: rtl/smi_chk.sv
module smi_chk #(
  parameter int NSOCK = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             route_q,
  input logic [NSOCK-1:0] trig,
  input logic [NSOCK-1:0] pend,
  input logic [NSOCK-1:0] smi_csc,
  input logic             csc_edge_mode,
  input logic             irq_serial_mode,
  input logic [2:0]       mfunc_sel,
  input logic             irq2_ser_req,
  input logic             irq2_par_oe,
  input logic             irq2_par_n
);
  AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && (trig != '0)) |=> ((pend & $past(trig)) == $past(trig))); // R2
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> ((pend & ~$past(pend)) == '0)); // R6
  AST_CSC_QUIET_IRQ2: assert property (@(posedge clk) disable iff (!rst_n)
    route_q |-> (smi_csc == '0)); // R9
  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (csc_edge_mode && !route_q && (smi_csc != '0)) |=>
      (!csc_edge_mode || ((smi_csc & $past(smi_csc)) == '0))); // R8
  AST_PAR_PIN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    irq2_par_oe |-> (mfunc_sel == 3'd3 || mfunc_sel == 3'd6)); // R10
  AST_SER_PAR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq2_ser_req && irq2_par_oe)); // R10
  AST_PIN_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !irq2_par_oe |-> irq2_par_n); // R10
  AST_SER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q && irq_serial_mode) |-> (irq2_ser_req == (pend != '0))); // R9
endmodule

bind pwr_smi_ctrl smi_chk #(.NSOCK(NSOCK)) u_smi_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .route_q(route_q), .trig(trig),
  .pend(pend), .smi_csc(smi_csc), .csc_edge_mode(csc_edge_mode),
  .irq_serial_mode(irq_serial_mode), .mfunc_sel(mfunc_sel),
  .irq2_ser_req(irq2_ser_req), .irq2_par_oe(irq2_par_oe),
  .irq2_par_n(irq2_par_n)
);

// File: tb/test_pwr_smi_ctrl.sv
module test_pwr_smi_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [0:0]  cfg_sock = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  sock_ctl_wr = '0, legacy_pwr_wr = '0, seq_launch = '0;
  logic        csc_edge_mode = 1'b0, irq_serial_mode = 1'b0;
  logic [2:0]  mfunc_sel = '0;
  logic [1:0]  smi_csc;
  logic        irq2_ser_req, irq2_par_oe, irq2_par_n;

  int vecs = 0, errs = 0;

  always #5 clk = ~clk;

  pwr_smi_ctrl i_pwr_smi_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sock(cfg_sock),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sock_ctl_wr(sock_ctl_wr),
    .legacy_pwr_wr(legacy_pwr_wr), .seq_launch(seq_launch),
    .csc_edge_mode(csc_edge_mode), .irq_serial_mode(irq_serial_mode),
    .mfunc_sel(mfunc_sel), .smi_csc(smi_csc), .irq2_ser_req(irq2_ser_req),
    .irq2_par_oe(irq2_par_oe), .irq2_par_n(irq2_par_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] word(input bit route, input bit st, input bit en);
    return (32'(route) << 26) | (32'(st) << 25) | (32'(en) << 24);
  endfunction

  task automatic wr(input bit sock, input bit route, input bit st, input bit en);
    cfg_wr = 1'b1; cfg_sock = sock; cfg_wdata = word(route, st, en);
    step();
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic fire(input bit sock);
    sock_ctl_wr[sock] = 1'b1; seq_launch[sock] = 1'b1;
    step();
    sock_ctl_wr = '0; seq_launch = '0;
  endtask

  task automatic rd_stat(input bit sock, output bit st);
    cfg_sock = sock; #1;
    st = cfg_rdata[25];
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    bit st;
    step(); step();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", cfg_rdata, 32'h0);
    chk("R1 csc", 32'(smi_csc), 0);
    chk("R1 pins", {irq2_ser_req, irq2_par_oe, irq2_par_n}, 32'b001);

    // R2 R3 R7 sweep over enable, write kinds, launch, socket
    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 2; c++)
        for (int l = 0; l < 2; l++)
          for (int n = 0; n < 2; n++)
            for (int s = 0; s < 2; s++) begin
              bit ex;
              wr(0, 0, 1, bit'(e)); wr(1, 0, 1, bit'(e));
              sock_ctl_wr[s] = bit'(c); legacy_pwr_wr[s] = bit'(l); seq_launch[s] = bit'(n);
              step();
              sock_ctl_wr = '0; legacy_pwr_wr = '0; seq_launch = '0;
              ex = bit'(e) & (bit'(c) | bit'(l)) & bit'(n);
              chk("R7 level csc", 32'(smi_csc), 32'(ex) << s);
              rd_stat(bit'(s), st);
              chk("R2 pending set", 32'(st), 32'(ex));
              chk("R3 readback", cfg_rdata, word(0, ex, bit'(e)));
            end

    // R6 trigger while disabled, enable later
    wr(0, 0, 1, 0); wr(1, 0, 1, 0);
    fire(0); fire(1);
    wr(0, 0, 0, 1); step(); step();
    chk("R6 no late set", 32'(smi_csc), 0);

    // R4 write-one-to-clear per socket
    fire(0); fire(1);
    wr(0, 0, 0, 1);
    chk("R4 zero keeps", 32'(smi_csc), 32'b11);
    wr(0, 0, 1, 1);
    chk("R4 clears one", 32'(smi_csc), 32'b10);

    // R5 set wins over clear in same cycle
    cfg_wr = 1'b1; cfg_sock = 1'b1; cfg_wdata = word(0, 1, 1);
    sock_ctl_wr[1] = 1'b1; seq_launch[1] = 1'b1;
    step();
    cfg_wr = 1'b0; sock_ctl_wr = '0; seq_launch = '0;
    rd_stat(1, st);
    chk("R5 set wins", 32'(st), 1);

    // R8 edge mode: one-cycle pulse
    wr(0, 0, 1, 1); wr(1, 0, 1, 1);
    csc_edge_mode = 1'b1; step();
    legacy_pwr_wr[0] = 1'b1; seq_launch[0] = 1'b1;
    step();
    legacy_pwr_wr = '0; seq_launch = '0;
    chk("R8 pulse", 32'(smi_csc), 32'b01);
    step();
    chk("R8 pulse ends", 32'(smi_csc), 0);
    rd_stat(0, st);
    chk("R8 flag held", 32'(st), 1);
    csc_edge_mode = 1'b0;

    // R9 route to IRQ2, serial mode
    irq_serial_mode = 1'b1;
    wr(0, 1, 0, 1);
    chk("R9 csc quiet", 32'(smi_csc), 0);
    chk("R9 serial req", {irq2_ser_req, irq2_par_oe}, 32'b10);
    wr(0, 1, 1, 1);
    chk("R9 serial idle", 32'(irq2_ser_req), 0);

    // R10 parallel mode over every mapping, pending and idle
    irq_serial_mode = 1'b0;
    fire(1);
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 8; m++) begin
        bit oe;
        mfunc_sel = 3'(m); #1;
        oe = (m == 3) || (m == 6);
        chk("R10 oe", 32'(irq2_par_oe), 32'(oe));
        chk("R10 pin", 32'(irq2_par_n), 32'(!(oe && p == 0)));
        chk("R10 no serial", 32'(irq2_ser_req), 0);
      end
      wr(1, 1, 1, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule